// File: doc/BRIEF.md
# Indexed Pixel Colour Pipeline with Cursor Overlay

This block turns a stream of 8-bit indexed pixels into 24-bit RGB. Each input beat carries the pixel's screen coordinate and its colour index. When a pixel lands inside a 64x64 hardware cursor window, a 2-bit cursor code is fetched from a pattern memory. A zero code lets the indexed palette colour show through. A non-zero code replaces the pixel with one of three cursor colours. A global blank control and an unsupported colour depth both force the output to black. A separate control bit hides the cursor.

Both stream edges use valid/ready. An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. An output beat is consumed on an edge where `out_valid` and `out_ready` are both high. The pipeline holds two register stages, and the whole pipeline stalls as a unit. `in_ready` is low only while the output stage holds a beat that the sink is refusing. While the output is refused, the output beat holds still, so the sink may wait for any number of cycles without losing data.

The palette, the pattern memory and the cursor colours are loaded through plain write ports, which a register block drives. Control inputs are sampled when a beat is accepted.

Top module: `pix_cursor_pipe`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The cursor colours reset to black.
- R2: A beat accepted on edge N, with `out_ready` high, shows `out_valid` high after edge N+1 but not after edge N. Outside the cursor its `out_rgb` equals palette entry `in_index`, packed as red[23:16], green[15:8], blue[7:0].
- R3: A pixel is inside the cursor window only when cx <= x < cx+64 and cy <= y < cy+64. The exclusive right and bottom edges fall at offset 64.
- R4: Inside the window, the pattern word address is (y-cy)*8 + (x-cx)/8. The pixel at offset k = (x-cx) mod 8 uses bits [2k+1:2k] of that word, so the least significant pair is the leftmost pixel.
- R5: Cursor code 0 shows the palette colour. Codes 1, 2 and 3 show cursor colours 0, 1 and 2, which are written through `ccol_addr` values 0, 1 and 2.
- R6: While `cursor_off` is 1, no pixel is treated as inside the cursor window.
- R7: While `force_blank` is 1, accepted beats come out with `out_rgb` = 0 and `out_blank` = 1, even inside the cursor.
- R8: `depth_code` 3 selects 8-bit indexed colour. Any other code raises `depth_bad` and makes accepted beats come out black with `out_blank` = 1.
- R9: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_rgb` and `out_blank` hold. The held beat and the beat behind it then come out in order.
- R10: `cursor_pos[23:12]` is the cursor x origin and `cursor_pos[11:0]` is the cursor y origin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Pipeline can accept a beat |
| in_x | input | 12 | Pixel column |
| in_y | input | 12 | Pixel row |
| in_index | input | 8 | Colour index from video memory |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Sink accepts the output beat |
| out_rgb | output | 24 | Output colour, red in bits 23:16 |
| out_blank | output | 1 | Beat was forced black |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette entry |
| pal_wdata | input | 24 | Palette colour |
| pat_we | input | 1 | Pattern write strobe |
| pat_addr | input | 9 | Pattern word address |
| pat_wdata | input | 16 | Pattern word |
| ccol_we | input | 1 | Cursor colour write strobe |
| ccol_addr | input | 2 | Cursor colour slot 0..2 |
| ccol_wdata | input | 24 | Cursor colour |
| cursor_pos | input | 24 | Cursor origin, x high, y low |
| cursor_off | input | 1 | Hide the cursor |
| force_blank | input | 1 | Force black output |
| depth_code | input | 3 | Colour depth selector |
| depth_bad | output | 1 | Depth selector is unsupported |

## Verification
The bench probes the cursor window edges at offsets -1, 0, 63 and 64 on both axes. A design with an inclusive far edge or an off-by-one origin would paint cursor colour one pixel outside the window or drop the last column. It places distinct codes in every pair of one pattern word, and a code in the second word of a row. A reversed pair order or a wrong row stride would return the wrong cursor colour. It swaps the x and y origins to catch transposed position fields. It holds the sink off across two queued beats, so a pipeline that advances under back-pressure would lose or reorder a beat. Blank and depth checks are made inside the cursor, so a design that lets cursor colours through the blanking shows colour where black is expected.

// File: rtl/pixpipe_pkg.sv
package pixpipe_pkg;
  localparam int CH_W     = 8;
  localparam int RGB_W    = 3 * CH_W;
  localparam int DEPTH_W  = 3;
  localparam logic [DEPTH_W-1:0] DEPTH_INDEXED8 = 3'd3;

  typedef logic [RGB_W-1:0] rgb_t;

  function automatic logic depth_supported(input logic [DEPTH_W-1:0] code);
    return code == DEPTH_INDEXED8;
  endfunction
endpackage

// File: rtl/pp_sync_ram.sv
module pp_sync_ram #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_cursor_window.sv
module pp_cursor_window #(
  parameter int COORD_W = 12,
  parameter int DIM     = 64,
  parameter int PIX_PER_WORD = 8,
  localparam int DLOG = $clog2(DIM),
  localparam int PLOG = $clog2(PIX_PER_WORD),
  localparam int WA_W = 2 * DLOG - PLOG
) (
  input  logic [COORD_W-1:0]   x,
  input  logic [COORD_W-1:0]   y,
  input  logic [2*COORD_W-1:0] pos,
  input  logic                 off,
  output logic                 hit,
  output logic [WA_W-1:0]      word_addr,
  output logic [PLOG-1:0]      pair_sel
);
  logic [COORD_W-1:0] cx, cy, dx, dy;
  logic in_x, in_y;

  always_comb begin
    cx   = pos[2*COORD_W-1:COORD_W];
    cy   = pos[COORD_W-1:0];
    dx   = x - cx;
    dy   = y - cy;
    in_x = (x >= cx) && (dx < COORD_W'(DIM));
    in_y = (y >= cy) && (dy < COORD_W'(DIM));
    hit  = in_x && in_y && !off;
    word_addr = {dy[DLOG-1:0], dx[DLOG-1:PLOG]};
    pair_sel  = dx[PLOG-1:0];
  end
endmodule

// File: rtl/pp_cursor_colors.sv
module pp_cursor_colors #(
  parameter int N_COL = 3,
  parameter int WIDTH = 24,
  localparam int CODE_W = $clog2(N_COL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CODE_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [CODE_W-1:0] code,
  output logic [WIDTH-1:0]  rgb
);
  logic [WIDTH-1:0] col [N_COL];

  for (genvar i = 0; i < N_COL; i++) begin : g_col
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   col[i] <= '0;
      else if (we && waddr == CODE_W'(i))           col[i] <= wdata;
    end
  end

  always_comb begin
    rgb = '0;
    for (int i = 0; i < N_COL; i++)
      if (code == CODE_W'(i + 1)) rgb = col[i];
  end
endmodule

// File: rtl/pix_cursor_pipe.sv
module pix_cursor_pipe
  import pixpipe_pkg::*;
#(
  parameter int COORD_W    = 12,
  parameter int IDX_W      = 8,
  parameter int CUR_DIM    = 64,
  parameter int PAT_W      = 16,
  parameter int CODE_W     = 2,
  parameter int N_CCOL     = 3,
  localparam int PIX_PER_WORD = PAT_W / CODE_W,
  localparam int PAT_DEPTH    = CUR_DIM * CUR_DIM / PIX_PER_WORD,
  localparam int PAT_AW       = $clog2(PAT_DEPTH),
  localparam int PLOG         = $clog2(PIX_PER_WORD),
  localparam int PAL_DEPTH    = 1 << IDX_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [COORD_W-1:0]   in_x,
  input  logic [COORD_W-1:0]   in_y,
  input  logic [IDX_W-1:0]     in_index,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [RGB_W-1:0]     out_rgb,
  output logic                 out_blank,
  input  logic                 pal_we,
  input  logic [IDX_W-1:0]     pal_addr,
  input  logic [RGB_W-1:0]     pal_wdata,
  input  logic                 pat_we,
  input  logic [PAT_AW-1:0]    pat_addr,
  input  logic [PAT_W-1:0]     pat_wdata,
  input  logic                 ccol_we,
  input  logic [CODE_W-1:0]    ccol_addr,
  input  logic [RGB_W-1:0]     ccol_wdata,
  input  logic [2*COORD_W-1:0] cursor_pos,
  input  logic                 cursor_off,
  input  logic                 force_blank,
  input  logic [DEPTH_W-1:0]   depth_code,
  output logic                 depth_bad
);
  logic              advance, take;
  logic              hit;
  logic [PAT_AW-1:0] word_addr;
  logic [PLOG-1:0]   pair_sel;
  rgb_t              pal_rdata, ccol_rgb, rgb_next;
  logic [PAT_W-1:0]  pat_rdata;
  logic              s1_valid, s1_hit, s1_blank;
  logic [PLOG-1:0]   s1_pair;
  logic [CODE_W-1:0] code;
  logic [CODE_W-1:0] out_code;

  assign depth_bad = !depth_supported(depth_code);
  assign advance   = !out_valid || out_ready;
  assign in_ready  = advance;
  assign take      = advance && in_valid;

  pp_cursor_window #(.COORD_W(COORD_W), .DIM(CUR_DIM), .PIX_PER_WORD(PIX_PER_WORD)) u_win (
    .x(in_x), .y(in_y), .pos(cursor_pos), .off(cursor_off),
    .hit(hit), .word_addr(word_addr), .pair_sel(pair_sel)
  );

  pp_sync_ram #(.WIDTH(RGB_W), .DEPTH(PAL_DEPTH)) u_pal (
    .clk(clk), .we(pal_we), .waddr(pal_addr), .wdata(pal_wdata),
    .re(take), .raddr(in_index), .rdata(pal_rdata)
  );

  pp_sync_ram #(.WIDTH(PAT_W), .DEPTH(PAT_DEPTH)) u_pat (
    .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
    .re(take), .raddr(word_addr), .rdata(pat_rdata)
  );

  pp_cursor_colors #(.N_COL(N_CCOL), .WIDTH(RGB_W)) u_ccol (
    .clk(clk), .rst_n(rst_n), .we(ccol_we), .waddr(ccol_addr),
    .wdata(ccol_wdata), .code(code), .rgb(ccol_rgb)
  );

  // Stage 1: memory lookups and per-beat flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_hit   <= 1'b0;
      s1_blank <= 1'b0;
      s1_pair  <= '0;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_hit   <= hit;
      s1_blank <= force_blank || depth_bad;
      s1_pair  <= pair_sel;
    end
  end

  always_comb begin
    code     = s1_hit ? pat_rdata[{s1_pair, 1'b0} +: CODE_W] : '0;
    rgb_next = s1_blank ? '0 : ((code == '0) ? pal_rdata : ccol_rgb);
  end

  // Stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
      out_blank <= 1'b0;
      out_code  <= '0;
    end else if (advance) begin
      out_valid <= s1_valid;
      out_rgb   <= rgb_next;
      out_blank <= s1_blank;
      out_code  <= code;
    end
  end

  // R9: a refused beat holds still
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_rgb) && $stable(out_blank));

  // R7, R8: a blanked beat is black
  p_black_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_blank |-> out_rgb == '0);

  // R2: accepted beat reaches stage 1
  p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid);

  // R2: stage 1 beat reaches output when pipeline advances
  p_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && in_ready |=> out_valid);

  // R5, R6: a pixel outside the window never carries a cursor code
  p_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && advance && !s1_hit |=> out_code == '0);

  // R8: unsupported depth marks the beat blank
  p_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && depth_bad |=> s1_blank);
endmodule

// File: tb/pix_cursor_pipe_tb.sv
module pix_cursor_pipe_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready;
  logic [11:0] in_x = 0, in_y = 0;
  logic [7:0] in_index = 0;
  logic out_valid, out_ready = 1;
  logic [23:0] out_rgb;
  logic out_blank;
  logic pal_we = 0; logic [7:0] pal_addr = 0; logic [23:0] pal_wdata = 0;
  logic pat_we = 0; logic [8:0] pat_addr = 0; logic [15:0] pat_wdata = 0;
  logic ccol_we = 0; logic [1:0] ccol_addr = 0; logic [23:0] ccol_wdata = 0;
  logic [23:0] cursor_pos = 0;
  logic cursor_off = 0, force_blank = 0;
  logic [2:0] depth_code = 3'd3;
  logic depth_bad;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_cursor_pipe u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_index(in_index), .out_valid(out_valid),
    .out_ready(out_ready), .out_rgb(out_rgb), .out_blank(out_blank),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_wdata(pat_wdata),
    .ccol_we(ccol_we), .ccol_addr(ccol_addr), .ccol_wdata(ccol_wdata),
    .cursor_pos(cursor_pos), .cursor_off(cursor_off), .force_blank(force_blank),
    .depth_code(depth_code), .depth_bad(depth_bad)
  );

  function automatic logic [23:0] pal_of(input logic [7:0] i);
    return {i, ~i, i ^ 8'h5A};
  endfunction

  // x, y, index, expected rgb ; cursor at x=100, y=50
  localparam logic [55:0] VEC [15] = '{
    {12'd10,  12'd10,  8'h00, 24'h00FF5A},  // R2 outside
    {12'd100, 12'd50,  8'h10, 24'h10EF4A},  // R3 R5 corner, code 0
    {12'd101, 12'd50,  8'h10, 24'h112233},  // R4 R5 code 1
    {12'd102, 12'd50,  8'h10, 24'h445566},  // R4 code 2
    {12'd103, 12'd50,  8'h10, 24'h778899},  // R4 code 3
    {12'd104, 12'd50,  8'h10, 24'h778899},  // R4 pair 4
    {12'd107, 12'd50,  8'h20, 24'h20DF7A},  // R4 pair 7 code 0
    {12'd109, 12'd51,  8'h30, 24'h112233},  // R4 word 9
    {12'd108, 12'd51,  8'h30, 24'h30CF6A},  // R4 word 9 pair 0
    {12'd163, 12'd113, 8'h40, 24'h778899},  // R3 last pixel
    {12'd164, 12'd113, 8'h40, 24'h40BF1A},  // R3 x edge
    {12'd163, 12'd114, 8'h41, 24'h41BE1B},  // R3 y edge
    {12'd99,  12'd50,  8'h42, 24'h42BD18},  // R3 left of origin
    {12'd100, 12'd49,  8'hA5, 24'hA55AFF},  // R3 above origin
    {12'd110, 12'd60,  8'hFF, 24'hFF00A5}   // R4 empty word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [11:0] x, input logic [11:0] y, input logic [7:0] idx,
                      input string req, input logic [23:0] exp, input logic exp_blank);
    @(negedge clk);
    in_valid = 1; in_x = x; in_y = y; in_index = idx;
    @(negedge clk);
    in_valid = 0;
    chk({req, " early"}, {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, out_valid}, 32'd1);
    chk({req, " rgb"}, {8'd0, out_rgb}, {8'd0, exp});
    chk({req, " blank"}, {31'd0, out_blank}, {31'd0, exp_blank});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expected=finish actual=timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1;
    // R1: cursor colours reset to black; code 1 pixel before loading colours
    for (int i = 0; i < 512; i++) begin
      @(negedge clk); pat_we = 1; pat_addr = 9'(i);
      pat_wdata = (i == 0) ? 16'h1BE4 : (i == 9) ? 16'h0004 : (i == 511) ? 16'hFFFF : 16'h0000;
    end
    for (int i = 0; i < 256; i++) begin
      @(negedge clk); pat_we = 0; pal_we = 1; pal_addr = 8'(i); pal_wdata = pal_of(8'(i));
    end
    @(negedge clk); pal_we = 0;
    cursor_pos = {12'd100, 12'd50};
    send(12'd101, 12'd50, 8'h10, "R1 ccol reset", 24'h000000, 1'b0);
    @(negedge clk); ccol_we = 1; ccol_addr = 0; ccol_wdata = 24'h112233;
    @(negedge clk); ccol_addr = 1; ccol_wdata = 24'h445566;
    @(negedge clk); ccol_addr = 2; ccol_wdata = 24'h778899;
    @(negedge clk); ccol_we = 0;

    for (int v = 0; v < 15; v++)
      send(VEC[v][55:44], VEC[v][43:32], VEC[v][31:24], $sformatf("R3 R4 R5 vec%0d", v),
           VEC[v][23:0], 1'b0);

    // R10: swapped origin fields
    cursor_pos = {12'd50, 12'd100};
    send(12'd101, 12'd50, 8'h11, "R10 swapped outside", pal_of(8'h11), 1'b0);
    send(12'd51, 12'd100, 8'h11, "R10 swapped inside", 24'h112233, 1'b0);
    cursor_pos = {12'd100, 12'd50};

    // R6
    cursor_off = 1;
    send(12'd101, 12'd50, 8'h12, "R6 cursor off", pal_of(8'h12), 1'b0);
    cursor_off = 0;

    // R7
    force_blank = 1;
    send(12'd101, 12'd50, 8'h13, "R7 blank in cursor", 24'h0, 1'b1);
    send(12'd10, 12'd10, 8'h13, "R7 blank outside", 24'h0, 1'b1);
    force_blank = 0;

    // R8
    depth_code = 3'd2;
    #1 chk("R8 depth_bad", {31'd0, depth_bad}, 32'd1);
    send(12'd103, 12'd50, 8'h14, "R8 bad depth", 24'h0, 1'b1);
    depth_code = 3'd4;
    send(12'd10, 12'd10, 8'h14, "R8 depth 4", 24'h0, 1'b1);
    depth_code = 3'd3;
    #1 chk("R8 depth ok", {31'd0, depth_bad}, 32'd0);

    // R9: back-pressure with two queued beats
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_x = 12'd10; in_y = 12'd10; in_index = 8'h21;
    @(negedge clk);
    in_x = 12'd103; in_y = 12'd50; in_index = 8'h22;
    @(negedge clk);
    in_valid = 0;
    chk("R9 first out", {8'd0, out_rgb}, {8'd0, pal_of(8'h21)});
    chk("R9 in_ready low", {31'd0, in_ready}, 32'd0);
    repeat (3) @(negedge clk);
    chk("R9 held valid", {31'd0, out_valid}, 32'd1);
    chk("R9 held rgb", {8'd0, out_rgb}, {8'd0, pal_of(8'h21)});
    out_ready = 1;
    @(negedge clk);
    chk("R9 second valid", {31'd0, out_valid}, 32'd1);
    chk("R9 second rgb", {8'd0, out_rgb}, 32'h00778899);
    @(negedge clk);
    chk("R9 drained", {31'd0, out_valid}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule